// File: doc/BRIEF.md
# Floating-Point Sign-Copy, Conditional-Move and Control-Register Unit

This unit sits beside a 64-bit floating-point register file. It produces the value to write back for three kinds of operation. The first kind builds a word from operand B and the top bits of operand A, which may be inverted. The second kind moves operand B into the destination when a test on the raw bit pattern of operand A passes. The third kind moves a value into or out of a floating-point control register.

The conditional moves look only at the sign bit and at the magnitude bits of A. They do not decode A as a number, so a word whose only set bit is the sign bit counts as zero. When a move condition fails, the write-enable drops and the result output repeats the current destination value.

A control-register write keeps only a masked field of the source word. It also sets the top bit of the register when any bit of a summary sub-field is set. The write takes effect at the next rising clock edge, so a read issued in the same cycle returns the old contents. The result and write-enable outputs are combinational from the inputs and the register.

Top module: `fsc_unit`

## Requirements
- R1: Opcode 1 (copy sign) gives result = {A[63], B[62:0]} with write-enable high.
- R2: Opcode 2 (copy inverted sign) gives result = {~A[63], B[62:0]} with write-enable high.
- R3: Opcode 3 (copy sign and exponent) gives result = {A[63:52], B[51:0]} with write-enable high.
- R4: Opcode 4 (move if zero) passes when A[62:0] is all zero, so both 0 and 0x8000000000000000 pass. Opcode 5 (move if nonzero) passes in exactly the other cases.
- R5: Opcode 6 (move if non-negative) passes when A[63] is 0 or A equals 0x8000000000000000. Opcode 7 (move if negative) passes when A[63] is 1 and A differs from 0x8000000000000000.
- R6: Opcode 8 (move if positive) passes when A[63] is 0 and A is nonzero. Opcode 9 (move if non-positive) passes when A[63] is 1 or A is all zero.
- R7: For opcodes 4 to 9, a passing condition gives result = B with write-enable high. A failing condition gives result = destination input with write-enable low.
- R8: Opcode 10 (control write) loads A & 0x7fff800000000000 into the control register at the next rising edge. The control output changes only at that edge. In the cycle of the write, write-enable is low and the result equals the destination input.
- R9: On a control write where any of the masked bits 57:52 is set, bit 63 of the control register is set to 1. Otherwise bit 63 is 0.
- R10: Opcode 11 (control read) gives result = the full 64-bit control register with write-enable high.
- R11: While the synchronous active-low reset is low, a rising edge clears the control register to zero.
- R12: Opcode 0 and opcodes 12 to 15 give write-enable low and result = destination input, and they leave the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation select (encoding in the requirements) |
| opnd_a | input | 64 | Operand A: sign source, condition operand or control-write source |
| opnd_b | input | 64 | Operand B: magnitude source or move source |
| dest_in | input | 64 | Current value of the destination register |
| res_out | output | 64 | Value to write back |
| wr_en | output | 1 | High when res_out should be written |
| ctl_out | output | 64 | Present control-register contents |

## Verification
Two situations are the hardest to reach from the ports. The first is the boundary words of the conditional moves: the pure sign-bit word, the all-zero word, and the word just above the pure sign-bit word. Random 64-bit operands almost never produce them. The second is a control write whose summary bits alone are set, and a read issued in the same cycle as a write. The stimulus draws half of its operands from a pool of these boundary words and places write-then-read pairs back to back. A behavioural model in the bench computes every expected value each cycle.

// File: rtl/fsc_pkg.sv
// Package: shared sizes, opcode encoding and the condition bundle for fsc_unit.
// Assumes 64-bit FP words with an 11-bit exponent below the sign bit.
package fsc_pkg;
    localparam int unsigned FW      = 64;   // FP word width
    localparam int unsigned EXP_W   = 11;   // exponent width
    localparam int unsigned CTL_LSB = 47;   // lowest kept control bit
    localparam int unsigned SUM_LSB = 52;   // summary-trigger field low bit
    localparam int unsigned SUM_MSB = 57;   // summary-trigger field high bit
    localparam int unsigned OP_W    = 4;    // opcode width

    typedef enum logic [OP_W-1:0] {
        OP_IDLE  = 4'd0,
        OP_CPS   = 4'd1,
        OP_CPSN  = 4'd2,
        OP_CPSE  = 4'd3,
        OP_MVEQ  = 4'd4,
        OP_MVNE  = 4'd5,
        OP_MVGE  = 4'd6,
        OP_MVLT  = 4'd7,
        OP_MVGT  = 4'd8,
        OP_MVLE  = 4'd9,
        OP_CTLWR = 4'd10,
        OP_CTLRD = 4'd11
    } fsc_op_e;

    typedef struct packed {
        logic eq;
        logic ne;
        logic ge;
        logic lt;
        logic gt;
        logic le;
    } fsc_cond_t;
endpackage

// File: rtl/fsc_signcopy.sv
// Module: builds the three sign-copy results from A and B.
// Assumes the sign is the top bit and the exponent sits just below it.
module fsc_signcopy #(
    parameter int unsigned DW    = fsc_pkg::FW,
    parameter int unsigned EXP_W = fsc_pkg::EXP_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] cps,
    output logic [DW-1:0] cpsn,
    output logic [DW-1:0] cpse
);
    localparam int unsigned HI_W = EXP_W + 1;   // sign plus exponent
    localparam int unsigned LO_W = DW - HI_W;   // fraction bits

    // Splice the top field of A onto the low field of B.
    always_comb begin
        cps  = {a[DW-1], b[DW-2:0]};
        cpsn = {~a[DW-1], b[DW-2:0]};
        cpse = {a[DW-1 -: HI_W], b[LO_W-1:0]};
    end
endmodule

// File: rtl/fsc_cond_eval.sv
// Module: evaluates the six move conditions on the raw bit pattern of A.
// Assumes a word with only the sign bit set counts as zero.
module fsc_cond_eval #(
    parameter int unsigned DW = fsc_pkg::FW
) (
    input  logic [DW-1:0]      a,
    output fsc_pkg::fsc_cond_t cond
);
    logic sgn;
    logic mag_zero;

    // Split A into its sign and a zero flag for the magnitude.
    always_comb begin
        sgn      = a[DW-1];
        mag_zero = ~|a[DW-2:0];
    end

    // Form every condition from the sign and the zero flag.
    always_comb begin
        cond.eq = mag_zero;
        cond.ne = ~mag_zero;
        cond.ge = ~sgn | mag_zero;
        cond.lt = sgn & ~mag_zero;
        cond.gt = ~sgn & ~mag_zero;
        cond.le = sgn | mag_zero;
    end
endmodule

// File: rtl/fsc_ctl_reg.sv
// Module: the control register with a masked load and a derived summary bit.
// Assumes the summary bit is the top bit and that reset is synchronous.
module fsc_ctl_reg #(
    parameter int unsigned DW      = fsc_pkg::FW,
    parameter int unsigned CTL_LSB = fsc_pkg::CTL_LSB,
    parameter int unsigned SUM_LSB = fsc_pkg::SUM_LSB,
    parameter int unsigned SUM_MSB = fsc_pkg::SUM_MSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [DW-1:0] src,
    output logic [DW-1:0] ctl_q
);
    localparam int unsigned KEEP_W = DW - 1 - CTL_LSB;
    localparam logic [DW-1:0] KEEP_MASK = {1'b0, {KEEP_W{1'b1}}, {CTL_LSB{1'b0}}};

    logic [DW-1:0] masked;
    logic          summary;
    logic [DW-1:0] ctl_d;

    // Keep the allowed field and derive the summary bit from the trigger field.
    always_comb begin
        masked  = src & KEEP_MASK;
        summary = |masked[SUM_MSB:SUM_LSB];
        ctl_d   = {summary, masked[DW-2:0]};
    end

    // Hold the register and load it on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_stb)
            ctl_q <= ctl_d;
    end
endmodule

// File: rtl/fsc_unit.sv
// Module: top of the sign-copy, conditional-move and control-register unit.
// Assumes unused opcodes act as idle. The result is combinational and the
// control register updates one edge after a write.
module fsc_unit #(
    parameter int unsigned DW    = fsc_pkg::FW,
    parameter int unsigned EXP_W = fsc_pkg::EXP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] dest_in,
    output logic [DW-1:0] res_out,
    output logic          wr_en,
    output logic [DW-1:0] ctl_out
);
    import fsc_pkg::*;

    logic [DW-1:0] cps_v;
    logic [DW-1:0] cpsn_v;
    logic [DW-1:0] cpse_v;
    fsc_cond_t     cond;
    fsc_op_e       op_e;
    logic          ctl_wr;
    logic          mv_hit;

    fsc_signcopy #(.DW(DW), .EXP_W(EXP_W)) u_copy (
        .a    (opnd_a),
        .b    (opnd_b),
        .cps  (cps_v),
        .cpsn (cpsn_v),
        .cpse (cpse_v)
    );

    fsc_cond_eval #(.DW(DW)) u_cond (
        .a    (opnd_a),
        .cond (cond)
    );

    fsc_ctl_reg #(.DW(DW)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (ctl_wr),
        .src    (opnd_a),
        .ctl_q  (ctl_out)
    );

    // Decode the opcode and find whether the selected move condition passes.
    always_comb begin
        op_e   = fsc_op_e'(op_sel);
        ctl_wr = (op_e == OP_CTLWR);
        unique case (op_e)
            OP_MVEQ: mv_hit = cond.eq;
            OP_MVNE: mv_hit = cond.ne;
            OP_MVGE: mv_hit = cond.ge;
            OP_MVLT: mv_hit = cond.lt;
            OP_MVGT: mv_hit = cond.gt;
            OP_MVLE: mv_hit = cond.le;
            default: mv_hit = 1'b0;
        endcase
    end

    // Choose the write-back value and the write-enable.
    always_comb begin
        res_out = dest_in;
        wr_en   = 1'b0;
        case (op_e)
            OP_CPS:   begin res_out = cps_v;   wr_en = 1'b1; end
            OP_CPSN:  begin res_out = cpsn_v;  wr_en = 1'b1; end
            OP_CPSE:  begin res_out = cpse_v;  wr_en = 1'b1; end
            OP_CTLRD: begin res_out = ctl_out; wr_en = 1'b1; end
            OP_MVEQ, OP_MVNE, OP_MVGE, OP_MVLT, OP_MVGT, OP_MVLE: begin
                res_out = mv_hit ? opnd_b : dest_in;
                wr_en   = mv_hit;
            end
            default: begin res_out = dest_in; wr_en = 1'b0; end
        endcase
    end
endmodule

// File: rtl/fsc_checker.sv
// Module: property checker for fsc_unit, attached with bind.
// Assumes the opcode encoding from fsc_pkg.
module fsc_checker #(
    parameter int unsigned DW = fsc_pkg::FW
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_sel,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b,
    input logic [DW-1:0] dest_in,
    input logic [DW-1:0] res_out,
    input logic          wr_en,
    input logic [DW-1:0] ctl_out
);
    import fsc_pkg::*;

    a_r1_copy_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CPS) |-> (wr_en && res_out == {opnd_a[DW-1], opnd_b[DW-2:0]}));

    a_r2_copy_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CPSN) |-> (wr_en && res_out[DW-1] != opnd_a[DW-1]
                                 && res_out[DW-2:0] == opnd_b[DW-2:0]));

    a_r4_eq_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_MVEQ && opnd_a[DW-2:0] == '0) |-> (wr_en && res_out == opnd_b));

    a_r5_lt_excl_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_MVLT && opnd_a == {1'b1, {(DW-1){1'b0}}}) |-> !wr_en);

    a_r7_false_keeps_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= OP_MVEQ && op_sel <= OP_MVLE && !wr_en) |-> (res_out == dest_in));

    a_r8_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CTLWR) |=> (ctl_out[DW-2:CTL_LSB] == $past(opnd_a[DW-2:CTL_LSB])
                                  && ctl_out[CTL_LSB-1:0] == '0));

    a_r9_summary_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CTLWR && |opnd_a[SUM_MSB:SUM_LSB]) |=> ctl_out[DW-1]);

    a_r10_ctl_read: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CTLRD) |-> (wr_en && res_out == ctl_out));

    a_r12_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != OP_CTLWR) |=> $stable(ctl_out));
endmodule

bind fsc_unit fsc_checker #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .dest_in (dest_in),
    .res_out (res_out),
    .wr_en   (wr_en),
    .ctl_out (ctl_out)
);

// File: tb/sim_fsc_unit.sv
// Bench: behavioural reference model of fsc_unit, compared every cycle.
module sim_fsc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [63:0] dest_in = '0;
    logic [63:0] res_out;
    logic        wr_en;
    logic [63:0] ctl_out;

    int vectors = 0;
    int errors  = 0;
    logic [63:0] mdl_ctl = '0;
    logic [63:0] rng = 64'h9e3779b97f4a7c15;
    logic [63:0] pool [8];

    localparam logic [63:0] SGN = 64'h8000000000000000;

    always #4 clk = ~clk;   // 125 MHz

    fsc_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .dest_in(dest_in), .res_out(res_out),
        .wr_en(wr_en), .ctl_out(ctl_out)
    );

    function automatic string req_of(int op);
        case (op)
            1: return "R1";   2: return "R2";   3: return "R3";
            4, 5: return "R4/R7";  6, 7: return "R5/R7";  8, 9: return "R6/R7";
            10: return "R8";  11: return "R10";
            default: return "R12";
        endcase
    endfunction

    // Reference: whether a move condition passes, using signed/unsigned views of A.
    function automatic bit mdl_pass(int op, logic [63:0] a);
        case (op)
            4: return (a << 1) == 0;
            5: return (a << 1) != 0;
            6: return a <= SGN;
            7: return a > SGN;
            8: return $signed(a) > 0;
            9: return $signed(a) <= 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] mdl_ctl_load(logic [63:0] a);
        logic [63:0] m;
        m = a & 64'h7fff800000000000;
        if ((m & 64'h03f0000000000000) != 0) m = m | SGN;   // R9
        return m;
    endfunction

    task automatic apply(int op, logic [63:0] a, logic [63:0] b, logic [63:0] d);
        logic [63:0] e_res;
        logic        e_wr;
        @(negedge clk);
        op_sel = op[3:0]; opnd_a = a; opnd_b = b; dest_in = d;
        e_res = d; e_wr = 1'b0;
        case (op)
            1: begin e_res = (a & SGN) | (b & ~SGN); e_wr = 1; end
            2: begin e_res = ((a & SGN) ^ SGN) | (b & ~SGN); e_wr = 1; end
            3: begin e_res = (a & 64'hfff0000000000000) | (b & 64'h000fffffffffffff); e_wr = 1; end
            4, 5, 6, 7, 8, 9: if (mdl_pass(op, a)) begin e_res = b; e_wr = 1; end
            11: begin e_res = mdl_ctl; e_wr = 1; end
            default: ;
        endcase
        #1;
        vectors++;
        if (res_out !== e_res || wr_en !== e_wr || ctl_out !== mdl_ctl) begin
            errors++;
            $display("FAIL %s op=%0d res=%h wr=%b ctl=%h expected res=%h wr=%b ctl=%h",
                     req_of(op), op, res_out, wr_en, ctl_out, e_res, e_wr, mdl_ctl);
        end
        if (op == 10) mdl_ctl = mdl_ctl_load(a);   // visible after the coming edge
    endtask

    task automatic check_ctl(string req, logic [63:0] exp_v);
        @(negedge clk); #1;
        vectors++;
        if (ctl_out !== exp_v) begin
            errors++;
            $display("FAIL %s ctl=%h expected %h", req, ctl_out, exp_v);
        end
    endtask

    function automatic logic [63:0] pick(logic [63:0] r);
        return (r[2:0] < 3'd4) ? pool[r[5:3]] : r;
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        pool[0] = 64'h0;              pool[1] = SGN;
        pool[2] = SGN | 64'h1;        pool[3] = 64'h1;
        pool[4] = 64'h7fffffffffffffff; pool[5] = '1;
        pool[6] = 64'h03f0000000000000; pool[7] = 64'h7fff800000000000;

        repeat (3) @(posedge clk);
        check_ctl("R11", 64'h0);                 // R11 reset state
        rst_n = 1'b1;

        // R1..R3 copy operations
        apply(1, SGN, 64'h123456789abcdef0, 64'h5);
        apply(1, 64'h0, '1, 64'h5);
        apply(2, SGN, 64'h0fedcba987654321, 64'h5);
        apply(2, 64'h0, 64'h0, 64'h5);
        apply(3, 64'hfff0000000000000, 64'h000abcdef0123456, 64'h5);
        apply(3, 64'h8010000000000000, '1, 64'h5);
        // R4..R7 boundary words for each move condition
        for (int op = 4; op <= 9; op++) begin
            for (int k = 0; k < 6; k++)
                apply(op, pool[k], 64'hb0b0b0b0b0b0b0b0, 64'hd0d0d0d0d0d0d0d0);
        end
        // R8/R9/R10 writes, reads and same-cycle ordering
        apply(11, 64'h0, 64'h0, 64'h7);
        apply(10, 64'h0400000000000000, 64'h0, 64'h7);   // R9 summary from bit 58? no: bit 58 outside field
        apply(11, 64'h0, 64'h0, 64'h7);
        apply(10, 64'h0010000000000000, 64'h0, 64'h7);   // R9 bit 52 set
        apply(11, 64'h0, 64'h0, 64'h7);
        apply(10, '1, 64'h0, 64'h7);                      // R8 mask
        apply(10, 64'h0000800000000000, 64'h0, 64'h7);
        apply(11, 64'h0, 64'h0, 64'h7);
        // R12 idle and unused opcodes
        for (int op = 12; op <= 15; op++) apply(op, '1, '1, 64'h3);
        apply(0, '1, '1, 64'h4);
        apply(11, 64'h0, 64'h0, 64'h7);
        // R11 reset clears a loaded register
        apply(10, 64'h7fff800000000000, 64'h0, 64'h0);
        @(negedge clk); op_sel = 4'd0; rst_n = 1'b0;
        check_ctl("R11", 64'h0);
        rst_n = 1'b1; mdl_ctl = '0;

        // Mixed stimulus with boundary words drawn half the time
        for (int i = 0; i < 600; i++) begin
            logic [63:0] ra, rb, rc;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17); ra = rng;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17); rb = rng;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17); rc = rng;
            apply(int'(rc[63:60]), pick(ra), rb, rc);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule